// File: doc/BRIEF.md
# Merged Min-Sum / Partial-Sum LLR Node

This block is one butterfly node of a successive-cancellation polar decoder. It takes two signed fixed-point log-likelihood ratios (LLRs) and produces one new LLR. In the check-node update (f) it uses the min-sum approximation. In the variable-node update (g) it adds or subtracts the two inputs under control of a partial-sum bit. A scheduler that walks the decoding tree feeds it one operation per cycle and reads back a registered result one clock later.

The two update kinds share a single adder/subtractor pair. The g path uses the sum and the difference directly. The f path does not compare magnitudes in a separate comparator. It reads the sign bits of that same sum and difference to decide which input has the smaller magnitude, and then rebuilds a two's-complement result from the chosen magnitude and the XOR of the input signs.

Top module: `sc_llr_node`

## Requirements
- R1: With `op_sel` = 1 (g) and `psum` = 0, the result is `llr_b + llr_a`, saturated as in R5.
- R2: With `op_sel` = 1 (g) and `psum` = 1, the result is `llr_b - llr_a`, saturated as in R5.
- R3: With `op_sel` = 0 (f), the result magnitude equals the smaller of the two input magnitudes.
- R4: With `op_sel` = 0 (f), the result is negative exactly when the input signs (bit W-1) differ and the smaller magnitude is nonzero; a zero magnitude gives a result of 0.
- R5: A g result above 2^(W-1)-1 becomes 2^(W-1)-1, and a result below -2^(W-1) becomes -2^(W-1). A result is never wrapped.
- R6: An input equal to -2^(W-1) is treated as -(2^(W-1)-1) in both modes.
- R7: `res_valid` equals `in_valid` delayed by one clock. The result of an operation presented with `in_valid` = 1 appears on `res_llr` after the next rising edge.
- R8: While `in_valid` = 0, `res_llr` keeps its value whatever the other inputs do.
- R9: A synchronous active-high `rst` clears `res_llr` to 0 and `res_valid` to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| op_sel | input | 1 | 0 selects f (min-sum), 1 selects g (add/subtract) |
| psum | input | 1 | Partial-sum bit for g: 0 adds, 1 subtracts `llr_a` from `llr_b` |
| llr_a | input | W | First LLR, two's complement |
| llr_b | input | W | Second LLR, two's complement |
| res_valid | output | 1 | Result valid, one cycle after `in_valid` |
| res_llr | output | W | Registered result LLR, two's complement |

## Verification
The hardest cases to reach are the ties and sign-boundary cases of the shared-subtractor selection: equal magnitudes with opposite signs (sum exactly zero), equal negative inputs (difference exactly zero), and the most negative code, which the clamp has to turn into a representable magnitude. Random stimulus seldom lands on these exact pairs. For that reason the stimulus sweeps every input pair in f mode and in both g variants, so every zero-sum, zero-difference and clamped combination occurs. A constrained random phase with a fixed seed follows, toggling `in_valid`, together with a reset applied mid-run, to exercise hold and latency.

// File: rtl/sc_node_pkg.sv
package sc_node_pkg;
  typedef enum logic {
    NODE_F = 1'b0,
    NODE_G = 1'b1
  } node_op_e;
endpackage

// File: rtl/sc_node_addsub.sv
// Shared adder/subtractor: the only arithmetic in the node.
module sc_node_addsub #(
  parameter int W = 6
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W:0]   sum_o,
  output logic signed [W:0]   diff_o
);
  localparam int EW = W + 1;

  function automatic logic signed [EW-1:0] ext(input logic signed [W-1:0] x);
    return {x[W-1], x};
  endfunction

  assign sum_o  = ext(b_i) + ext(a_i);
  assign diff_o = ext(b_i) - ext(a_i);
endmodule

// File: rtl/sc_node_minsum.sv
// f update: selection comes from the shared sum/difference sign bits.
module sc_node_minsum #(
  parameter int W = 6
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  input  logic signed [W:0]   sum_i,
  input  logic signed [W:0]   diff_i,
  output logic                a_smaller_o,
  output logic [W-2:0]        mag_o,
  output logic signed [W-1:0] f_o
);
  localparam int MW = W - 1;

  function automatic logic [MW-1:0] to_mag(input logic signed [W-1:0] x);
    logic [W-1:0] n;
    n = -x;
    return x[W-1] ? n[MW-1:0] : x[MW-1:0];
  endfunction

  function automatic logic signed [W-1:0] to_tc(input logic s, input logic [MW-1:0] m);
    logic [W-1:0] p;
    p = {1'b0, m};
    return s ? -p : p;
  endfunction

  logic sa, sb, same_sign, res_sign;
  assign sa        = a_i[W-1];
  assign sb        = b_i[W-1];
  assign same_sign = (sa == sb);
  assign res_sign  = sa ^ sb;

  // Same signs: (b - a) sign equals sign of a when |a| <= |b|.
  // Opposite signs: (b + a) sign equals sign of b when |a| <= |b|.
  assign a_smaller_o = same_sign ? (diff_i[W] == sa) : (sum_i[W] == sb);
  assign mag_o       = a_smaller_o ? to_mag(a_i) : to_mag(b_i);
  assign f_o         = to_tc(res_sign, mag_o);
endmodule

// File: rtl/sc_node_gsat.sv
// g update: pick sum or difference and saturate to W bits.
module sc_node_gsat #(
  parameter int W = 6
) (
  input  logic signed [W:0]   sum_i,
  input  logic signed [W:0]   diff_i,
  input  logic                psum_i,
  output logic                sat_hi_o,
  output logic                sat_lo_o,
  output logic signed [W-1:0] g_o
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] raw;
  assign raw      = psum_i ? diff_i : sum_i;
  assign sat_hi_o = (raw[W] != raw[W-1]) && !raw[W];
  assign sat_lo_o = (raw[W] != raw[W-1]) &&  raw[W];
  assign g_o      = sat_hi_o ? MAXV : (sat_lo_o ? MINV : raw[W-1:0]);
endmodule

// File: rtl/sc_node_outreg.sv
module sc_node_outreg #(
  parameter int W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vld_i,
  input  logic signed [W-1:0] d_i,
  output logic                vld_o,
  output logic signed [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/sc_llr_node.sv
module sc_llr_node
  import sc_node_pkg::*;
#(
  parameter int W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                op_sel,
  input  logic                psum,
  input  logic signed [W-1:0] llr_a,
  input  logic signed [W-1:0] llr_b,
  output logic                res_valid,
  output logic signed [W-1:0] res_llr
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] clamp_low(input logic signed [W-1:0] x);
    return (x == MINV) ? -MAXV : x;
  endfunction

  // Named internal events for the assertions.
  logic signed [W-1:0] a_c, b_c, f_res, g_res, node_res;
  logic signed [W:0]   sum_w, diff_w;
  logic [W-2:0]        f_mag;
  logic                a_smaller, g_sat_hi, g_sat_lo;
  node_op_e            op;

  assign op  = node_op_e'(op_sel);
  assign a_c = clamp_low(llr_a);
  assign b_c = clamp_low(llr_b);

  sc_node_addsub #(.W(W)) u_addsub (
    .a_i(a_c), .b_i(b_c), .sum_o(sum_w), .diff_o(diff_w)
  );

  sc_node_minsum #(.W(W)) u_minsum (
    .a_i(a_c), .b_i(b_c), .sum_i(sum_w), .diff_i(diff_w),
    .a_smaller_o(a_smaller), .mag_o(f_mag), .f_o(f_res)
  );

  sc_node_gsat #(.W(W)) u_gsat (
    .sum_i(sum_w), .diff_i(diff_w), .psum_i(psum),
    .sat_hi_o(g_sat_hi), .sat_lo_o(g_sat_lo), .g_o(g_res)
  );

  assign node_res = (op == NODE_G) ? g_res : f_res;

  sc_node_outreg #(.W(W)) u_outreg (
    .clk(clk), .rst(rst), .vld_i(in_valid), .d_i(node_res),
    .vld_o(res_valid), .q_o(res_llr)
  );

  // R3: the selected magnitude never exceeds either input magnitude
  a_r3_min_mag: assert property (@(posedge clk) disable iff (rst)
    (int'(f_mag) <= (a_c[W-1] ? -int'(a_c) : int'(a_c))) &&
    (int'(f_mag) <= (b_c[W-1] ? -int'(b_c) : int'(b_c))));

  // R4: f result sign follows the XOR of input signs
  a_r4_f_sign: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == NODE_F && f_mag != '0) |=>
      (res_llr[W-1] == $past(llr_a[W-1] ^ llr_b[W-1])));

  // R5: overflow in g pins the output to the range limits
  a_r5_sat_hi: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == NODE_G && g_sat_hi) |=> (res_llr == MAXV));
  a_r5_sat_lo: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == NODE_G && g_sat_lo) |=> (res_llr == MINV));

  // R6: the clamped operands never carry the most negative code
  a_r6_clamp: assert property (@(posedge clk) disable iff (rst)
    (a_c != MINV) && (b_c != MINV));

  // R7: valid is delayed by exactly one clock
  a_r7_valid_on: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  a_r7_valid_off: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);

  // R8: result holds while no operation is presented
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_llr));

  // R9: reset clears the output register
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (!res_valid && res_llr == '0));
endmodule

// File: tb/sc_llr_node_tb_top.sv
module sc_llr_node_tb_top;
  localparam int W       = 6;
  localparam int CLK_PER = 10;
  localparam int LIM     = (1 << (W - 1)) - 1;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic                op_sel = 1'b0;
  logic                psum = 1'b0;
  logic signed [W-1:0] llr_a = '0;
  logic signed [W-1:0] llr_b = '0;
  logic                res_valid;
  logic signed [W-1:0] res_llr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PER / 2) clk = ~clk;

  sc_llr_node #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .psum(psum),
    .llr_a(llr_a), .llr_b(llr_b), .res_valid(res_valid), .res_llr(res_llr)
  );

  // Model: integers, clamp, then the textbook min-sum / add-subtract.
  function automatic int model(input int a, input int b, input bit g, input bit u);
    int ac, bc, ma, mb, m, r;
    ac = (a == -LIM - 1) ? -LIM : a;
    bc = (b == -LIM - 1) ? -LIM : b;
    if (!g) begin
      ma = (ac < 0) ? -ac : ac;
      mb = (bc < 0) ? -bc : bc;
      m  = (ma < mb) ? ma : mb;
      return ((ac < 0) != (bc < 0)) ? -m : m;
    end
    r = u ? (bc - ac) : (bc + ac);
    if (r > LIM) r = LIM;
    if (r < -LIM - 1) r = -LIM - 1;
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string pick_tag(input int a, input int b, input bit g, input bit u);
    int raw;
    if (a == -LIM - 1 || b == -LIM - 1) return "R6";
    if (!g) return "R3 R4";
    raw = u ? (b - a) : (b + a);
    if (raw > LIM || raw < -LIM - 1) return "R5";
    return u ? "R2" : "R1";
  endfunction

  // Present one operation, then sample after the capturing edge.
  task automatic op_cycle(input int a, input int b, input bit g, input bit u);
    llr_a = a[W-1:0]; llr_b = b[W-1:0]; op_sel = g; psum = u; in_valid = 1'b1;
    @(negedge clk);
    check("R7 valid", int'(res_valid), 1);
    check(pick_tag(a, b, g, u), int'(res_llr), model(a, b, g, u));
  endtask

  initial begin
    int exp_llr;
    void'($urandom(32'h5ca1_ab1e));
    repeat (2) @(negedge clk);
    check("R9 reset valid", int'(res_valid), 0);
    check("R9 reset llr", int'(res_llr), 0);
    rst = 1'b0;

    // Directed corners
    op_cycle(-32, 5, 1'b0, 1'b0);   // R6: clamp in f
    op_cycle(-32, -32, 1'b1, 1'b0); // R5/R6: -62 saturates low
    op_cycle(31, 31, 1'b1, 1'b0);   // R5 high
    op_cycle(7, -7, 1'b0, 1'b0);    // zero sum tie
    op_cycle(-9, -9, 1'b0, 1'b0);   // zero difference tie
    op_cycle(0, -12, 1'b0, 1'b0);   // zero magnitude gives 0 (R4)

    // Exhaustive sweep: f, g add, g subtract
    for (int m = 0; m < 3; m++)
      for (int a = -LIM - 1; a <= LIM; a++)
        for (int b = -LIM - 1; b <= LIM; b++)
          op_cycle(a, b, m != 0, m == 2);

    // R8: idle cycles with changing inputs keep the result
    exp_llr = model(13, -4, 1'b1, 1'b1);
    op_cycle(13, -4, 1'b1, 1'b1);
    for (int k = 0; k < 8; k++) begin
      in_valid = 1'b0;
      llr_a = W'($urandom); llr_b = W'($urandom);
      op_sel = 1'($urandom); psum = 1'($urandom);
      @(negedge clk);
      check("R7 no valid", int'(res_valid), 0);
      check("R8 hold", int'(res_llr), exp_llr);
    end

    // Constrained random with gaps
    for (int k = 0; k < 3000; k++) begin
      bit v, g, u;
      int a, b;
      v = ($urandom % 4) != 0;
      g = 1'($urandom); u = 1'($urandom);
      a = int'($urandom % (2 * LIM + 2)) - LIM - 1;
      b = int'($urandom % (2 * LIM + 2)) - LIM - 1;
      llr_a = a[W-1:0]; llr_b = b[W-1:0]; op_sel = g; psum = u; in_valid = v;
      if (v) exp_llr = model(a, b, g, u);
      @(negedge clk);
      check("R7 random valid", int'(res_valid), int'(v));
      check(v ? pick_tag(a, b, g, u) : "R8 random hold", int'(res_llr), exp_llr);
    end

    // R9: reset in mid-run
    llr_a = 6'sd20; llr_b = 6'sd20; op_sel = 1'b1; psum = 1'b0; in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R9 midrun valid", int'(res_valid), 0);
    check("R9 midrun llr", int'(res_llr), 0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule